// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block produces the doorbell interrupts that let the two sides of a shared two-port memory signal each other. Each side, called left and right here, owns one mailbox word at the top of the address space. The right side's mailbox is the all-ones address. The left side's mailbox is the address one below it. Writing the opposite side's mailbox rings that side's interrupt. The owner silences its interrupt by reading its own mailbox.

The block watches each port's select, write strobe, output enable, address and the busy indication from the contention arbiter. A port that is busy can neither ring the other side nor silence its own interrupt. The data in the mailbox is stored by the memory array, not here, and has no meaning to this logic. Both interrupt outputs are active low and registered. They update on the clock edge that samples the access.

Top module: `mbx_irq_top`

## Requirements
- R1: While `rst` is high, and on the first edge after it, both `l_irq_n` and `r_irq_n` are 1 (deasserted).
- R2: A left write (`l_sel`=1, `l_wr`=1, `l_busy`=0) to address 2^ADDR_W-1 drives `r_irq_n` to 0 one clock edge later.
- R3: A right write (`r_sel`=1, `r_wr`=1, `r_busy`=0) to address 2^ADDR_W-2 drives `l_irq_n` to 0 one clock edge later.
- R4: An owner read clears that port's flag to 1 one edge later. An owner read is `sel`=1, `wr`=0, `oe`=1 and `busy`=0 at the port's own mailbox: left at 2^ADDR_W-2, right at 2^ADDR_W-1.
- R5: A port reading the opposite side's mailbox changes neither flag.
- R6: While a port's `busy` is 1, its writes do not set the opposite side's flag.
- R7: While a port's `busy` is 1, its reads of its own mailbox do not clear its flag.
- R8: When a set and a clear of the same flag occur in the same cycle, the flag ends asserted (0).
- R9: None of the following changes a flag: a read with `oe`=0, any access with `sel`=0, a write to any address other than the top two, or a port writing its own mailbox.
- R10: Without a qualifying set or clear, each flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left port access select |
| l_wr | input | 1 | Left port write strobe (0 = read) |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | ADDR_W | Left port address |
| l_busy | input | 1 | Left port lost arbitration |
| r_sel | input | 1 | Right port access select |
| r_wr | input | 1 | Right port write strobe (0 = read) |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | ADDR_W | Right port address |
| r_busy | input | 1 | Right port lost arbitration |
| l_irq_n | output | 1 | Interrupt to left side, active low |
| r_irq_n | output | 1 | Interrupt to right side, active low |

## Verification
The bench builds the block with ADDR_W=5, giving 32 addresses. Random addresses are biased toward the two mailbox words, but the other thirty addresses still appear often enough to exercise rejection of non-mailbox writes. The narrow width makes the all-ones decode and its neighbour reachable under random stimulus. It also makes simultaneous set-and-clear collisions and busy-blocked accesses occur many times within a few thousand cycles.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  function automatic int unsigned box_of(input side_e s, input int unsigned aw);
    int unsigned top;
    top = (1 << aw) - 1;
    return (s == SIDE_R) ? top : top - 1;
  endfunction
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int ADDR_W   = 12,
  parameter int OWN_BOX  = 4094,
  parameter int PEER_BOX = 4095
) (
  input  logic              sel,
  input  logic              wr,
  input  logic              oe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              ring_peer,
  output logic              ack_own
);
  localparam logic [ADDR_W-1:0] OWN_A  = OWN_BOX[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] PEER_A = PEER_BOX[ADDR_W-1:0];

  logic granted;
  assign granted   = sel && !busy;
  assign ring_peer = granted && wr && (addr == PEER_A);
  assign ack_own   = granted && !wr && oe && (addr == OWN_A);
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst)      irq_n <= 1'b1;
    else if (set) irq_n <= 1'b0;
    else if (clr) irq_n <= 1'b1;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (set && clr) |=> !irq_n);
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  localparam int NPORT = 2;
  localparam logic [ADDR_W-1:0] L_BOX = box_of(SIDE_L, ADDR_W);
  localparam logic [ADDR_W-1:0] R_BOX = box_of(SIDE_R, ADDR_W);

  logic              sel_v  [NPORT];
  logic              wr_v   [NPORT];
  logic              oe_v   [NPORT];
  logic              busy_v [NPORT];
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic              ring_v [NPORT];
  logic              ack_v  [NPORT];
  logic              irq_v  [NPORT];

  assign sel_v[0]  = l_sel;  assign sel_v[1]  = r_sel;
  assign wr_v[0]   = l_wr;   assign wr_v[1]   = r_wr;
  assign oe_v[0]   = l_oe;   assign oe_v[1]   = r_oe;
  assign busy_v[0] = l_busy; assign busy_v[1] = r_busy;
  assign addr_v[0] = l_addr; assign addr_v[1] = r_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int OWN  = box_of(side_e'(p), ADDR_W);
    localparam int PEER = box_of(side_e'(1 - p), ADDR_W);
    mbx_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
      .sel(sel_v[p]), .wr(wr_v[p]), .oe(oe_v[p]), .busy(busy_v[p]),
      .addr(addr_v[p]), .ring_peer(ring_v[p]), .ack_own(ack_v[p])
    );
    mbx_flag u_flag (
      .clk(clk), .rst(rst), .set(ring_v[NPORT-1-p]), .clr(ack_v[p]),
      .irq_n(irq_v[p])
    );
  end

  assign l_irq_n = irq_v[0];
  assign r_irq_n = irq_v[1];

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (l_irq_n && r_irq_n));
  p_ring_right_r2: assert property (@(posedge clk) disable iff (rst)
    (l_sel && l_wr && !l_busy && l_addr == R_BOX) |=> !r_irq_n);
  p_ring_left_r3: assert property (@(posedge clk) disable iff (rst)
    (r_sel && r_wr && !r_busy && r_addr == L_BOX) |=> !l_irq_n);
  p_left_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (l_sel && !l_wr && l_oe && !l_busy && l_addr == L_BOX &&
     !(r_sel && r_wr && !r_busy && r_addr == L_BOX)) |=> l_irq_n);
  p_left_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (r_irq_n && l_busy) |=> r_irq_n);
  p_right_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (!r_irq_n && r_busy) |=> !r_irq_n);
  p_left_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!r_sel && !l_sel) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

// File: tb/tb_mbx_irq_top.sv
module tb_mbx_irq_top;
  localparam int AW = 5;
  localparam logic [AW-1:0] RBOX = {AW{1'b1}};
  localparam logic [AW-1:0] LBOX = RBOX - 1'b1;

  logic clk = 1'b0, rst = 1'b1;
  logic l_sel = 0, l_wr = 0, l_oe = 0, l_busy = 0;
  logic r_sel = 0, r_wr = 0, r_oe = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;
  int checks = 0, fails = 0;
  logic exp_l = 1'b1, exp_r = 1'b1;
  bit done = 0;

  always #5 clk = ~clk;

  mbx_irq_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_busy(l_busy),
    .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_busy(r_busy),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n));

  function automatic logic next_flag(logic cur, logic set, logic clr);
    if (set) return 1'b0;
    if (clr) return 1'b1;
    return cur;
  endfunction

  task automatic check(string tag);
    checks++;
    if (l_irq_n !== exp_l || r_irq_n !== exp_r) begin
      fails++;
      $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b", tag, l_irq_n, r_irq_n, exp_l, exp_r);
    end
  endtask

  // drive one access pair at negedge, compute model, check after the edge
  task automatic step(logic ls, logic lw, logic lo, logic [AW-1:0] la, logic lb,
                      logic rs, logic rw, logic ro, logic [AW-1:0] ra, logic rb,
                      string tag);
    logic set_r, set_l, clr_l, clr_r;
    @(negedge clk);
    l_sel = ls; l_wr = lw; l_oe = lo; l_addr = la; l_busy = lb;
    r_sel = rs; r_wr = rw; r_oe = ro; r_addr = ra; r_busy = rb;
    set_r = ls && lw && !lb && la == RBOX;
    set_l = rs && rw && !rb && ra == LBOX;
    clr_l = ls && !lw && lo && !lb && la == LBOX;
    clr_r = rs && !rw && ro && !rb && ra == RBOX;
    exp_l = next_flag(exp_l, set_l, clr_l);
    exp_r = next_flag(exp_r, set_r, clr_r);
    @(posedge clk); #1;
    check(tag);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int unsigned k = $urandom_range(0, 9);
    if (k < 4) return RBOX;
    if (k < 7) return LBOX;
    return AW'($urandom_range(0, (1 << AW) - 1));
  endfunction

  initial begin
    void'($urandom(32'h1F0B));
    repeat (3) @(posedge clk);
    #1;
    exp_l = 1; exp_r = 1;
    check("R1 reset");
    @(negedge clk); rst = 0;
    @(posedge clk); #1; check("R1 after reset");
    // directed corners
    step(1,1,0,RBOX,1, 0,0,0,0,0, "R6 busy left write");
    step(1,1,0,RBOX,0, 0,0,0,0,0, "R2 left rings right");
    step(0,0,0,0,0, 1,0,1,LBOX,0, "R5 right reads left box");
    step(0,0,0,0,0, 1,0,0,RBOX,0, "R9 read without oe");
    step(0,0,0,0,0, 1,1,0,RBOX,0, "R9 own-box write");
    step(0,0,0,0,0, 1,0,1,RBOX,1, "R7 busy read");
    step(0,0,0,0,0, 0,0,0,0,0, "R10 hold");
    step(0,0,0,0,0, 1,0,1,RBOX,0, "R4 right clears");
    step(0,0,0,0,0, 1,1,0,5'd3,0, "R9 other address");
    step(0,0,0,0,0, 1,1,0,LBOX,0, "R3 right rings left");
    step(1,0,1,LBOX,0, 1,1,0,LBOX,0, "R8 set beats clear");
    step(1,0,1,LBOX,0, 0,0,0,0,0, "R4 left clears");
    step(1,1,0,RBOX,0, 1,0,1,RBOX,0, "R8 set beats clear right");
    // random
    for (int i = 0; i < 4000; i++) begin
      logic ls, lw, lo, lb, rs, rw, ro, rb;
      ls = $urandom_range(0,3) != 0; lw = $urandom_range(0,1); lo = $urandom_range(0,3) != 0;
      lb = $urandom_range(0,4) == 0;
      rs = $urandom_range(0,3) != 0; rw = $urandom_range(0,1); ro = $urandom_range(0,3) != 0;
      rb = $urandom_range(0,4) == 0;
      step(ls, lw, lo, pick_addr(), lb, rs, rw, ro, pick_addr(), rb,
           "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule